// File: doc/BRIEF.md
# Keyed Reset Pulse Generator

This block turns a one-cycle expiry trigger from a watchdog counter into an external reset pulse of programmable length. The pulse length is counted in microsecond ticks that arrive on a strobe input, so the block's clock rate does not affect the duration. A programmed width of N gives a pulse of N+1 ticks. Once a pulse starts it always runs to its full length, and further triggers have no effect until it ends.

A single configuration register holds the width field in its low bits and two mode flags in its top bits: the asserted level (high or low) and the drive style (push-pull or open-drain). Every write replaces the width. The mode flags change only when the top byte of the write carries one of four key values, so software that only means to change the width cannot flip the pad behaviour by accident. The pad is presented as a data value and an output-enable, so both drive styles can be modelled by the surrounding pad logic.

Top module: `rstpulse_gen`

## Requirements
- R1: After reset the register reads 0x000000FF (active-low, open-drain, width 0xFF), and the pad is idle: pad_oe=0 and pad_out=0.
- R2: Every write with cfg_we=1 loads cfg_wdata[19:0] into the width field, and cfg_rdata[19:0] shows it from the next cycle.
- R3: A write whose top byte is 0xA5 sets the polarity flag (cfg_rdata[31]=1, active-high). A top byte of 0x5A clears it (active-low). The drive flag is unchanged.
- R4: A write whose top byte is 0xA8 sets the drive flag (cfg_rdata[30]=1, push-pull). A top byte of 0x8A clears it (open-drain). The polarity flag is unchanged.
- R5: A write with any other top byte leaves cfg_rdata[31:30] unchanged, and its width field is still loaded.
- R6: cfg_rdata[29:20] always reads zero, whatever was written there.
- R7: When trigger is sampled high while idle, the pulse is asserted at the pads two clock edges later. It stays asserted until width+1 tick_us strobes have been seen, and is released at the pads two edges after the last of those strobes.
- R8: A trigger that arrives during a pulse is ignored: the pulse neither restarts nor lengthens.
- R9: The pulse length is fixed by the width held when the pulse starts. A width write during a pulse does not change the running pulse.
- R10: In push-pull mode pad_oe=1 at all times, and pad_out shows the line level: high while asserted if active-high, low while asserted if active-low.
- R11: In open-drain mode pad_out=0, and pad_oe=1 exactly when the line must be low. That is during the pulse if active-low, and outside the pulse if active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle microsecond tick strobe |
| trigger | input | 1 | Watchdog expiry strobe that starts a pulse |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration register contents |
| pad_out | output | 1 | Pad data value |
| pad_oe | output | 1 | Pad output-enable |

## Verification
The bench aims at the width encoding off by one: a width of 0 must still give one full tick, and a design that counts N ticks would release one tick early. It checks that ordinary writes cannot disturb the mode flags. A design that decodes a key loosely, or that clears the flags when the top byte is not a key, would change the pad's polarity or drive without being asked. It retriggers and rewrites the width during a pulse; a design that reloaded the timer would stretch the pulse. It runs all four polarity and drive combinations, because active-high open-drain is the case where a design that inverted the wrong signal would drive the line during the pulse instead of releasing it.

// File: rtl/rstpulse_pkg.sv
package rstpulse_pkg;
  // Top-byte key values; the mode flags move only on these.
  localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
  localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

  typedef struct packed {
    logic pol_high;   // 1: line asserted high
    logic push_pull;  // 1: push-pull, 0: open-drain
  } pad_mode_t;
endpackage

// File: rtl/rstpulse_cfg.sv
module rstpulse_cfg
  import rstpulse_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int WIDTH_W   = 20,
  parameter int DEF_WIDTH = 'hFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [WIDTH_W-1:0] width,
  output pad_mode_t          mode,
  output logic [DATA_W-1:0]  rdata
);
  localparam int RSV_W = DATA_W - 2 - WIDTH_W;

  logic [7:0] key;
  assign key = wdata[DATA_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      width          <= WIDTH_W'(DEF_WIDTH);
      mode.pol_high  <= 1'b0;
      mode.push_pull <= 1'b0;
    end else if (we) begin
      width <= wdata[WIDTH_W-1:0];
      if (key == KEY_POL_HIGH)      mode.pol_high  <= 1'b1;
      else if (key == KEY_POL_LOW)  mode.pol_high  <= 1'b0;
      if (key == KEY_DRV_PP)        mode.push_pull <= 1'b1;
      else if (key == KEY_DRV_OD)   mode.push_pull <= 1'b0;
    end
  end

  assign rdata = {mode.pol_high, mode.push_pull, {RSV_W{1'b0}}, width};
endmodule

// File: rtl/rstpulse_timer.sv
module rstpulse_timer #(
  parameter int WIDTH_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               trigger,
  input  logic [WIDTH_W-1:0] width,
  output logic               active,
  output logic [WIDTH_W-1:0] remain
);
  localparam logic [WIDTH_W-1:0] ONE = WIDTH_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      remain <= '0;
    end else if (!active) begin
      if (trigger) begin
        active <= 1'b1;
        remain <= width;
      end
    end else if (tick) begin
      if (remain == '0) active <= 1'b0;
      else              remain <= remain - ONE;
    end
  end
endmodule

// File: rtl/rstpulse_pad.sv
module rstpulse_pad
  import rstpulse_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      active,
  input  pad_mode_t mode,
  output logic      pad_out,
  output logic      pad_oe
);
  logic level;
  assign level = mode.pol_high ? active : !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else if (mode.push_pull) begin
      pad_out <= level;
      pad_oe  <= 1'b1;
    end else begin
      pad_out <= 1'b0;
      pad_oe  <= !level;
    end
  end
endmodule

// File: rtl/rstpulse_gen.sv
module rstpulse_gen
  import rstpulse_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int WIDTH_W   = 20,
  parameter int DEF_WIDTH = 'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_us,
  input  logic              trigger,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              pad_out,
  output logic              pad_oe
);
  logic [WIDTH_W-1:0] cur_width;
  pad_mode_t          cur_mode;
  logic               pulse_active;
  logic [WIDTH_W-1:0] pulse_remain;

  rstpulse_cfg #(.DATA_W(DATA_W), .WIDTH_W(WIDTH_W), .DEF_WIDTH(DEF_WIDTH)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .width(cur_width), .mode(cur_mode), .rdata(cfg_rdata)
  );

  rstpulse_timer #(.WIDTH_W(WIDTH_W)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_us), .trigger(trigger),
    .width(cur_width), .active(pulse_active), .remain(pulse_remain)
  );

  rstpulse_pad u_pad (
    .clk(clk), .rst(rst), .active(pulse_active), .mode(cur_mode),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: rtl/rstpulse_chk.sv
module rstpulse_chk #(
  parameter int DATA_W  = 32,
  parameter int WIDTH_W = 20
) (
  input logic               clk,
  input logic               rst,
  input logic               tick_us,
  input logic               cfg_we,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic [DATA_W-1:0]  cfg_rdata,
  input logic               pad_out,
  input logic               pad_oe,
  input logic               active,
  input logic [WIDTH_W-1:0] remain
);
  logic key_hit;
  assign key_hit = (cfg_wdata[DATA_W-1 -: 8] == 8'hA5) || (cfg_wdata[DATA_W-1 -: 8] == 8'h5A) ||
                   (cfg_wdata[DATA_W-1 -: 8] == 8'hA8) || (cfg_wdata[DATA_W-1 -: 8] == 8'h8A);

  p_width_load_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata[WIDTH_W-1:0] == $past(cfg_wdata[WIDTH_W-1:0]));

  p_flags_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !key_hit) |=> cfg_rdata[DATA_W-1 -: 2] == $past(cfg_rdata[DATA_W-1 -: 2]));

  p_rsv_zero_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[DATA_W-3:WIDTH_W] == '0);

  p_pulse_end_r7: assert property (@(posedge clk) disable iff (rst)
    (active && tick_us && remain == '0) |=> !active);

  p_no_reload_r8: assert property (@(posedge clk) disable iff (rst)
    (active && !tick_us) |=> (active && $stable(remain)));

  p_pp_oe_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[DATA_W-2] |=> pad_oe);

  p_od_low_r11: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[DATA_W-2] |=> !pad_out);
endmodule

bind rstpulse_gen rstpulse_chk #(.DATA_W(DATA_W), .WIDTH_W(WIDTH_W)) u_chk (
  .clk(clk), .rst(rst), .tick_us(tick_us), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .active(pulse_active), .remain(pulse_remain)
);

// File: tb/tb_rstpulse_gen.sv
module tb_rstpulse_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_us = 1'b0;
  logic        trigger = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pad_out, pad_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rstpulse_gen dut (
    .clk(clk), .rst(rst), .tick_us(tick_us), .trigger(trigger),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  // Expected pads: {pad_out, pad_oe}
  function automatic logic [1:0] exp_pads(input bit asserted, input bit hi, input bit pp);
    bit lvl;
    lvl = hi ? asserted : !asserted;
    if (pp) return {lvl, 1'b1};
    return {1'b0, !lvl};
  endfunction

  task automatic chk_pads(input string req, input bit asserted, input bit hi, input bit pp);
    chk32(req, {30'd0, pad_out, pad_oe}, {30'd0, exp_pads(asserted, hi, pp)});
  endtask

  task automatic fire();
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    cyc(2);
  endtask

  task automatic tick();
    @(negedge clk); tick_us = 1'b1;
    @(negedge clk); tick_us = 1'b0;
    cyc(2);
  endtask

  task automatic set_mode(input bit hi, input bit pp, input logic [19:0] w);
    wr({hi ? 8'hA5 : 8'h5A, 4'h0, w});
    wr({pp ? 8'hA8 : 8'h8A, 4'h0, w});
  endtask

  task automatic t_reset();
    chk32("R1 reset readback", cfg_rdata, 32'h0000_00FF);
    chk_pads("R1 reset pads", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_writes();
    wr(32'h0000_0123);
    chk32("R2 width write", cfg_rdata, 32'h0000_0123);
    wr(32'h3FF0_0007);
    chk32("R6 reserved bits read zero", cfg_rdata, 32'h0000_0007);
    wr(32'hA500_0010);
    chk32("R3 key sets active-high", cfg_rdata, 32'h8000_0010);
    wr(32'hA800_0011);
    chk32("R4 key sets push-pull", cfg_rdata, 32'hC000_0011);
    wr(32'h1200_0005);
    chk32("R5 non-key top byte keeps flags", cfg_rdata, 32'hC000_0005);
    wr(32'hA400_0006);
    chk32("R5 near-key top byte keeps flags", cfg_rdata, 32'hC000_0006);
    wr(32'h5A00_0005);
    chk32("R3 key sets active-low", cfg_rdata, 32'h4000_0005);
    wr(32'h8A00_0003);
    chk32("R4 key sets open-drain", cfg_rdata, 32'h0000_0003);
  endtask

  task automatic t_pulse(input bit hi, input bit pp, input int n);
    set_mode(hi, pp, 20'(n));
    chk_pads(pp ? "R10 idle pads" : "R11 idle pads", 1'b0, hi, pp);
    fire();
    for (int k = 0; k <= n; k++) begin
      chk_pads(pp ? "R10 R7 asserted" : "R11 R7 asserted", 1'b1, hi, pp);
      tick();
    end
    chk_pads("R7 released after width+1 ticks", 1'b0, hi, pp);
  endtask

  task automatic t_retrigger();
    set_mode(1'b0, 1'b0, 20'd4);
    fire();
    tick(); tick();
    fire();
    chk_pads("R8 still asserted after retrigger", 1'b1, 1'b0, 1'b0);
    tick(); tick();
    chk_pads("R8 asserted before last tick", 1'b1, 1'b0, 1'b0);
    tick();
    chk_pads("R8 retrigger did not extend", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_midwrite();
    set_mode(1'b1, 1'b1, 20'd2);
    fire();
    tick();
    wr(32'h0000_000A);
    chk32("R9 width updated mid-pulse", cfg_rdata, 32'hC000_000A);
    tick();
    chk_pads("R9 asserted before last tick", 1'b1, 1'b1, 1'b1);
    tick();
    chk_pads("R9 pulse kept captured width", 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_writes();
    t_pulse(1'b0, 1'b0, 0);
    t_pulse(1'b0, 1'b0, 3);
    t_pulse(1'b1, 1'b1, 3);
    t_pulse(1'b0, 1'b1, 2);
    t_pulse(1'b1, 1'b0, 3);
    t_retrigger();
    t_midwrite();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule